// File: doc/BRIEF.md
# Synthesizer Divider with Lock Qualification

This block is the digital core of a phase-locked frequency synthesizer. A reference prescaler turns a stream of reference-clock enables into a slow comparison tick. The 10.24 MHz reference is divided by 1024, which gives 10 kHz. A programmable divider counts pulses of the squared-up loop-IF signal and emits a feedback tick once per N pulses. N comes from a 12-bit binary ratio word and spans 100 to 499, one value for each 10 kHz channel across a 4 MHz band.

A tri-state phase-frequency comparator sets a raise request on each comparison tick and a lower request on each feedback tick. It clears both once both have been seen. These two pulses steer the external oscillator. A lock qualifier measures how wide the comparator pulses are in each reference period and raises a lock flag after a run of tight periods. It drops the flag after repeated wide ones.

The lock flag directly drives three enables: the transmit exciter, the channel display and the receive second oscillator. When lock is lost, transmission stops, the display blanks and reception is muted.

Top module: `synth_lock_core`

## Requirements
- R1: `cmp_tick` is a one-cycle pulse, asserted in the clock cycle after every 1024th cycle in which `ref_en` is high, counted from reset.
- R2: `ratio_code` is read as an unsigned binary N (bit 0 is the LSB). `fb_tick` is a one-cycle pulse asserted in the cycle after every Nth `if_pulse`.
- R3: A change of `ratio_code` does not alter the divide period in progress. The new N applies from the period that starts after the next feedback tick.
- R4: `steer_up` rises in the cycle after `cmp_tick` and `steer_dn` in the cycle after `fb_tick`. The cycle after the later of the two, both are low. Coincident ticks produce no pulse, and both outputs are never high together.
- R5: At each `cmp_tick` the period is judged in-window when the widest comparator pulse since the previous judgement lasted fewer than 4 clocks. `lock_ok` rises after 16 consecutive in-window judgements.
- R6: While locked, a single out-of-window judgement is tolerated. Two in a row clear `lock_ok`.
- R7: A ratio below 100 divides by 100, and a ratio above 499 divides by 499.
- R8: `ratio_err` rises when `ratio_code` is outside 100..499 and stays high until reset. In-range codes never raise it.
- R9: `exciter_en`, `display_en` and `lo2_en` always equal `lock_ok`. After reset, `lock_ok`, the steering outputs and `ratio_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | One enable per reference-clock cycle |
| if_pulse | input | 1 | One enable per loop-IF cycle |
| ratio_code | input | 12 | Binary divide ratio N |
| cmp_tick | output | 1 | Comparison tick (reference / 1024) |
| fb_tick | output | 1 | Divided feedback tick |
| steer_up | output | 1 | Raise-frequency request |
| steer_dn | output | 1 | Lower-frequency request |
| ratio_err | output | 1 | Sticky out-of-range ratio flag |
| lock_ok | output | 1 | Qualified lock flag |
| exciter_en | output | 1 | Transmit exciter enable |
| display_en | output | 1 | Channel display enable |
| lo2_en | output | 1 | Receive second oscillator enable |

## Verification
Two events can fall in the same cycle. The first pairing is the comparison tick with the feedback tick. In that case the comparator must stay silent rather than emit a one-cycle pulse. The second pairing is a lock judgement with the last cycle of a comparator pulse, and that final cycle must still be counted in the width. The bench provokes the first case by placing the Nth IF pulse in the same cycle as the 1024th reference enable. It provokes the second by placing the Nth pulse 3 and 5 cycles early, and once 3 cycles late. It then judges per-period counts of steering cycles, the exact cycle of every tick, and the lock flag at the boundary counts of 15/16 good and 1/2 bad periods.

// File: rtl/synth_pkg.sv
package synth_pkg;
  localparam int RATIO_W_DEF = 12;

  typedef enum logic [1:0] {
    V_IDLE,
    V_GOOD,
    V_BAD
  } verdict_t;
endpackage

// File: rtl/ref_prescaler.sv
module ref_prescaler #(
  parameter int DIV = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_en,
  output logic cmp_tick
);
  localparam int W = $clog2(DIV);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      cmp_tick <= 1'b0;
    end else begin
      cmp_tick <= 1'b0;
      if (ref_en) begin
        if (cnt == W'(DIV - 1)) begin
          cnt      <= '0;
          cmp_tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R1: a comparison tick only ever follows a reference enable
  assert_tick_source_R1: assert property (@(posedge clk) disable iff (rst)
    cmp_tick |-> $past(ref_en));
endmodule

// File: rtl/prog_divider.sv
module prog_divider #(
  parameter int W    = 12,
  parameter int NMIN = 100,
  parameter int NMAX = 499
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         if_pulse,
  input  logic [W-1:0] ratio_code,
  output logic         fb_tick,
  output logic         ratio_err
);
  logic         below, above;
  logic [W-1:0] n_clamp, n_act, cnt;

  assign below = ratio_code < W'(NMIN);
  assign above = ratio_code > W'(NMAX);

  always_comb begin
    if (below)      n_clamp = W'(NMIN);
    else if (above) n_clamp = W'(NMAX);
    else            n_clamp = ratio_code;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n_act     <= n_clamp;
      cnt       <= '0;
      fb_tick   <= 1'b0;
      ratio_err <= 1'b0;
    end else begin
      fb_tick <= 1'b0;
      if (below || above) ratio_err <= 1'b1;
      if (if_pulse) begin
        if (cnt == n_act - 1'b1) begin
          cnt     <= '0;
          fb_tick <= 1'b1;
          n_act   <= n_clamp;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R7: the active ratio always lies inside the legal span
  assert_ratio_bounds_R7: assert property (@(posedge clk) disable iff (rst)
    (n_act >= W'(NMIN)) && (n_act <= W'(NMAX)));
  // R8: once raised, the error flag holds
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ratio_err |=> ratio_err);
  // R2: a feedback tick only ever follows an IF pulse
  assert_tick_source_R2: assert property (@(posedge clk) disable iff (rst)
    fb_tick |-> $past(if_pulse));
endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate (
  input  logic clk,
  input  logic rst,
  input  logic ref_evt,
  input  logic fb_evt,
  output logic up,
  output logic dn
);
  logic up_n, dn_n;

  always_comb begin
    up_n = up | ref_evt;
    dn_n = dn | fb_evt;
    if (up_n && dn_n) begin
      up_n = 1'b0;
      dn_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up_n;
      dn <= dn_n;
    end
  end

  // R4: the two steering requests are mutually exclusive
  assert_pfd_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
    !(up && dn));
  // R4: a raise request starts only after a comparison tick
  assert_up_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(up) |-> $past(ref_evt));
  // R4: a lower request starts only after a feedback tick
  assert_dn_start_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dn) |-> $past(fb_evt));
endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier
  import synth_pkg::*;
#(
  parameter int WIN  = 4,
  parameter int ACQ  = 16,
  parameter int DROP = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic eval,
  output logic locked
);
  localparam int RW = $clog2(WIN + 1);
  localparam int GW = $clog2(ACQ + 1);
  localparam int BW = $clog2(DROP + 1);

  logic [RW-1:0] run_q, run_d, peak_q, peak_d;
  logic [GW-1:0] good_q;
  logic [BW-1:0] bad_q;
  verdict_t      verdict;

  always_comb begin
    if (!active)                run_d = '0;
    else if (run_q == RW'(WIN)) run_d = run_q;
    else                        run_d = run_q + 1'b1;
    peak_d = (run_d > peak_q) ? run_d : peak_q;
    if (!eval)                   verdict = V_IDLE;
    else if (peak_d < RW'(WIN))  verdict = V_GOOD;
    else                         verdict = V_BAD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      peak_q <= '0;
      good_q <= '0;
      bad_q  <= '0;
      locked <= 1'b0;
    end else begin
      run_q  <= run_d;
      peak_q <= eval ? '0 : peak_d;
      case (verdict)
        V_GOOD: begin
          if (locked) bad_q <= '0;
          else if (good_q == GW'(ACQ - 1)) begin
            locked <= 1'b1;
            good_q <= '0;
          end else good_q <= good_q + 1'b1;
        end
        V_BAD: begin
          if (!locked) good_q <= '0;
          else if (bad_q == BW'(DROP - 1)) begin
            locked <= 1'b0;
            bad_q  <= '0;
          end else bad_q <= bad_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R5: lock is only granted on a judgement cycle
  assert_lock_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(eval));
  // R6: lock is only withdrawn on a judgement cycle
  assert_drop_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(eval));
endmodule

// File: rtl/synth_lock_core.sv
module synth_lock_core #(
  parameter int REF_DIV      = 1024,
  parameter int RATIO_W      = synth_pkg::RATIO_W_DEF,
  parameter int N_MIN        = 100,
  parameter int N_MAX        = 499,
  parameter int WIN_CLKS     = 4,
  parameter int ACQ_PERIODS  = 16,
  parameter int DROP_PERIODS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ref_en,
  input  logic               if_pulse,
  input  logic [RATIO_W-1:0] ratio_code,
  output logic               cmp_tick,
  output logic               fb_tick,
  output logic               steer_up,
  output logic               steer_dn,
  output logic               ratio_err,
  output logic               lock_ok,
  output logic               exciter_en,
  output logic               display_en,
  output logic               lo2_en
);
  logic pfd_active;

  ref_prescaler #(.DIV(REF_DIV)) u_prescale (
    .clk(clk), .rst(rst), .ref_en(ref_en), .cmp_tick(cmp_tick)
  );

  prog_divider #(.W(RATIO_W), .NMIN(N_MIN), .NMAX(N_MAX)) u_divider (
    .clk(clk), .rst(rst), .if_pulse(if_pulse), .ratio_code(ratio_code),
    .fb_tick(fb_tick), .ratio_err(ratio_err)
  );

  pfd_tristate u_pfd (
    .clk(clk), .rst(rst), .ref_evt(cmp_tick), .fb_evt(fb_tick),
    .up(steer_up), .dn(steer_dn)
  );

  assign pfd_active = steer_up | steer_dn;

  lock_qualifier #(.WIN(WIN_CLKS), .ACQ(ACQ_PERIODS), .DROP(DROP_PERIODS)) u_lock (
    .clk(clk), .rst(rst), .active(pfd_active), .eval(cmp_tick), .locked(lock_ok)
  );

  // R9: all three downstream enables follow the qualified lock flag
  assign exciter_en = lock_ok;
  assign display_en = lock_ok;
  assign lo2_en     = lock_ok;
endmodule

// File: tb/test_synth_lock_core.sv
module test_synth_lock_core;
  logic        clk = 1'b0;
  logic        rst, ref_en, if_pulse;
  logic [11:0] ratio_code;
  logic cmp_tick, fb_tick, steer_up, steer_dn, ratio_err;
  logic lock_ok, exciter_en, display_en, lo2_en;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int fb_q[$];
  int ref_q[$];
  int cum_up = 0, cum_dn = 0, snap_up = 0, snap_dn = 0;
  bit done = 1'b0;

  synth_lock_core i_synth_lock_core (
    .clk(clk), .rst(rst), .ref_en(ref_en), .if_pulse(if_pulse),
    .ratio_code(ratio_code), .cmp_tick(cmp_tick), .fb_tick(fb_tick),
    .steer_up(steer_up), .steer_dn(steer_dn), .ratio_err(ratio_err),
    .lock_ok(lock_ok), .exciter_en(exciter_en), .display_en(display_en),
    .lo2_en(lo2_en)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic chk_lock(string what, int exp);
    chk({what, " lock_ok"}, int'(lock_ok), exp);
    chk({"R9 exciter_en ", what}, int'(exciter_en), exp);
    chk({"R9 display_en ", what}, int'(display_en), exp);
    chk({"R9 lo2_en ", what}, int'(lo2_en), exp);
  endtask

  // scoreboard monitor: pops expected tick cycles as ticks appear
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (fb_tick) begin
        if (fb_q.size() == 0) chk("R2 unexpected divider tick", cyc, -1);
        else chk("R2/R3 divider tick cycle", cyc, fb_q.pop_front());
      end
      if (cmp_tick) begin
        if (ref_q.size() == 0) chk("R1 unexpected comparison tick", cyc, -1);
        else chk("R1 comparison tick cycle", cyc, ref_q.pop_front());
      end
    end
  end

  // driver: one reference period of 1024 enables; n IF pulses, the last d cycles early
  // (d < 0: the last IF pulse comes -d-1 idle cycles after the period)
  task automatic run_period(int n, int d, int new_ratio, int exp_lock,
                            int exp_up, int exp_dn, string tag);
    for (int c = 0; c < 1024; c++) begin
      @(negedge clk);
      cum_up += int'(steer_up);
      cum_dn += int'(steer_dn);
      if (c == 1) begin
        if (exp_up >= 0) begin
          chk({"R4 up cycles prev period ", tag}, cum_up - snap_up, exp_up);
          chk({"R4 dn cycles prev period ", tag}, cum_dn - snap_dn, exp_dn);
        end
        snap_up = cum_up;
        snap_dn = cum_dn;
      end
      ref_en   = 1'b1;
      if_pulse = ((c >= 10) && (c < 10 + 2 * (n - 1)) && ((c - 10) % 2 == 0)) ||
                 (c == 1023 - d);
      if (c == 1023 - d) fb_q.push_back(cyc + 1);
      if (c == 1023) ref_q.push_back(cyc + 1);
      if (c == 5 && new_ratio >= 0) ratio_code = 12'(new_ratio);
      if (c == 100 && exp_lock >= 0) chk_lock(tag, exp_lock);
    end
  endtask

  initial begin
    int tup, tdn;
    rst = 1'b1; ref_en = 1'b0; if_pulse = 1'b0; ratio_code = 12'd200;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_lock("R9 after reset", 0);
    chk("R9 steer_up after reset", int'(steer_up), 0);
    chk("R9 steer_dn after reset", int'(steer_dn), 0);
    chk("R9 ratio_err after reset", int'(ratio_err), 0);

    // coincident ticks: no steering, 14 good judgements
    for (int i = 1; i <= 14; i++)
      run_period(200, 0, -1, -1, (i > 1) ? 0 : -1, 0, "R4 aligned");
    run_period(200, 0, -1, 0, 0, 0, "R5 after 14 good");
    run_period(200, 0, -1, 0, 0, 0, "R5 after 15 good");
    run_period(200, 0, -1, 1, 0, 0, "R5 after 16 good");
    // ratio change mid-period: old N still applies to this period
    run_period(200, 0, 350, 1, 0, 0, "R3 change mid-period");
    run_period(350, 0, -1, 1, 0, 0, "R3 new ratio");
    // divider 3 cycles early: lower pulses of width 3 stay in window
    run_period(350, 3, -1, 1, 0, 0, "R5 width 3");
    run_period(350, 3, -1, 1, 0, 3, "R5 width 3 held");
    run_period(350, 3, -1, 1, 0, 3, "R5 width 3 held again");
    chk("R8 in-range codes leave ratio_err low", int'(ratio_err), 0);
    // 5 cycles early: out of window
    run_period(350, 5, -1, 1, 0, 3, "R6 before bad");
    run_period(350, 5, -1, 1, 0, 5, "R6 one bad tolerated");
    run_period(350, 0, 50, 0, 0, 5, "R6 two bad drop");
    chk("R8 ratio_err after code 50", int'(ratio_err), 1);
    run_period(100, 0, 4000, 0, 0, 0, "R7 clamp low to 100");
    run_period(499, 0, 300, 0, 0, 0, "R7 clamp high to 499");
    chk("R8 ratio_err sticky with code 300", int'(ratio_err), 1);
    // divider 3 cycles late: raise pulse of width 3
    run_period(300, -3, -1, 0, 0, 0, "R4 late feedback");
    tup = 0; tdn = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      tup += int'(steer_up);
      tdn += int'(steer_dn);
      ref_en   = 1'b0;
      if_pulse = (k == 2);
      if (k == 2) fb_q.push_back(cyc + 1);
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      tup += int'(steer_up);
      tdn += int'(steer_dn);
      if_pulse = 1'b0;
    end
    chk("R4 raise cycles with late feedback", tup, 3);
    chk("R4 lower cycles with late feedback", tdn, 0);
    chk("R2 pending divider ticks", fb_q.size(), 0);
    chk("R1 pending comparison ticks", ref_q.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule